// File: doc/BRIEF.md
# Adaptive Access-Threshold Tuner

This block retunes the access-count threshold that a hybrid-memory migration unit uses to decide when a row in the slow, dense memory is worth copying into the fast DRAM cache. It watches three single-cycle event pulses: a migration, a read served from DRAM and a write served from DRAM. Each pulse is counted for the current quantum, and an external strobe marks the end of the quantum.

On the strobe the block works out a net benefit for the quantum. The benefit is the device cycles saved by serving accesses from DRAM. The cost is the bus cycles spent on migrations. The block compares the net benefit with the previous quantum's value and moves the threshold one step by a hill-climbing rule. The new threshold and cleared counters take effect on the next cycle. The row-miss threshold is not adapted and is always driven as a fixed value of 2.

The climbing direction is held in a three-state machine:
- `ST_UNSET`: after reset, no evaluation has happened yet.
- `ST_CLIMB_UP`: the last step raised the threshold.
- `ST_CLIMB_DOWN`: the last step lowered the threshold.

On every strobe, each state moves to `ST_CLIMB_UP` if the chosen step is upward and to `ST_CLIMB_DOWN` otherwise. Without a strobe, each state holds. The step is chosen as one of three decisions:
- raise: the net benefit is negative.
- follow: the net benefit is at least zero and strictly greater than the stored previous value. The threshold steps in the current direction, and `ST_UNSET` counts as upward.
- lower: every other case.

Top module: `hc_threshold_tuner`

## Requirements
- R1: After reset, `thr_a` equals A_INIT (4), `thr_valid` is 0, the stored previous net benefit is 0 and all event counts are 0.
- R2: Each event counter adds one per pulse during a quantum and saturates at 2^CNT_W-1. A pulse in the strobe cycle is counted in the following quantum, because the counters are reloaded with the strobe-cycle pulse value.
- R3: The net benefit is evaluated on the strobe as follows, with products and sums wide enough never to overflow:
  - cost is migrations × `lat_mig`;
  - benefit is reads × max(`lat_rd_slow`−`lat_rd_fast`, 0) + writes × max(`lat_wr_slow`−`lat_wr_fast`, 0);
  - the net benefit is benefit − cost, held as a signed value.
- R4: A negative net benefit raises `thr_a` by one and sets the direction to up.
- R5: A net benefit that is at least zero and strictly greater than the previous one steps `thr_a` by one in the current direction. This is upward in `ST_UNSET` and `ST_CLIMB_UP`, and downward in `ST_CLIMB_DOWN`.
- R6: Any other net benefit lowers `thr_a` by one and sets the direction to down.
- R7: Every strobe stores the quantum's net benefit as the previous value for the next comparison.
- R8: `thr_a` changes only on the cycle after a strobe, moves by at most one, and stays within 1..A_MAX. A step past a limit leaves it at that limit.
- R9: `thr_valid` rises on the cycle after the first strobe and then stays high.
- R10: `thr_m` is always 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_mig | input | 1 | Pulse: one row migration |
| ev_rd | input | 1 | Pulse: one read served from DRAM |
| ev_wr | input | 1 | Pulse: one write served from DRAM |
| q_end | input | 1 | Quantum-end strobe |
| lat_mig | input | LAT_W | Bus cycles per migration |
| lat_rd_slow | input | LAT_W | Slow-memory read latency |
| lat_rd_fast | input | LAT_W | DRAM read latency |
| lat_wr_slow | input | LAT_W | Slow-memory write latency |
| lat_wr_fast | input | LAT_W | DRAM write latency |
| thr_a | output | A_W | Current access threshold |
| thr_m | output | A_W | Fixed miss threshold (2) |
| thr_valid | output | 1 | Threshold has been evaluated at least once |

## Verification
The following hold on every cycle and are checked by assertions:
- `thr_a` stays in range and changes only after a strobe.
- A negative net benefit forces a raise.
- A non-improving net benefit forces a lower.
- The counters reload and saturate as required.
- `thr_valid` rises only after a strobe and never falls.

Some behaviour needs whole quanta of stimulus, so only the bench scenarios show it:
- whether the follow rule keeps the remembered direction;
- whether the stored previous value steers the next decision;
- whether latency differences below zero are clamped;
- whether a pulse in the strobe cycle lands in the next quantum;
- whether saturation changes a decision.

// File: rtl/hc_pkg.sv
package hc_pkg;
    typedef enum logic [1:0] {
        ST_UNSET      = 2'd0,
        ST_CLIMB_UP   = 2'd1,
        ST_CLIMB_DOWN = 2'd2
    } hc_state_e;

    typedef enum logic [1:0] {
        DEC_RAISE  = 2'd0,
        DEC_FOLLOW = 2'd1,
        DEC_LOWER  = 2'd2
    } hc_dec_e;

    localparam int EV_MIG = 0;
    localparam int EV_RD  = 1;
    localparam int EV_WR  = 2;
    localparam int EV_NUM = 3;
endpackage

// File: rtl/hc_event_counter.sv
module hc_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= {{(CNT_W-1){1'b0}}, ev};
        end else if (ev && cnt != CNT_MAX) begin
            cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    // R2: strobe reloads the count with the strobe-cycle pulse
    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == {{(CNT_W-1){1'b0}}, $past(ev)});
    // R2: a full counter stays full until cleared
    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
endmodule

// File: rtl/hc_net_calc.sv
module hc_net_calc #(
    parameter int CNT_W = 16,
    parameter int LAT_W = 10,
    localparam int PROD_W = CNT_W + LAT_W,
    localparam int NET_W  = PROD_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        n_mig,
    input  logic [CNT_W-1:0]        n_rd,
    input  logic [CNT_W-1:0]        n_wr,
    input  logic [LAT_W-1:0]        lat_mig,
    input  logic [LAT_W-1:0]        lat_rd_slow,
    input  logic [LAT_W-1:0]        lat_rd_fast,
    input  logic [LAT_W-1:0]        lat_wr_slow,
    input  logic [LAT_W-1:0]        lat_wr_fast,
    output logic signed [NET_W-1:0] net
);
    logic [LAT_W-1:0]  gain_rd, gain_wr;
    logic [PROD_W-1:0] cost, ben_rd, ben_wr;
    logic [PROD_W:0]   benefit;

    // Negative latency gaps count as no saving
    always_comb begin
        gain_rd = (lat_rd_slow > lat_rd_fast) ? lat_rd_slow - lat_rd_fast : '0;
        gain_wr = (lat_wr_slow > lat_wr_fast) ? lat_wr_slow - lat_wr_fast : '0;
    end

    always_comb begin
        cost    = PROD_W'(n_mig) * PROD_W'(lat_mig);
        ben_rd  = PROD_W'(n_rd)  * PROD_W'(gain_rd);
        ben_wr  = PROD_W'(n_wr)  * PROD_W'(gain_wr);
        benefit = {1'b0, ben_rd} + {1'b0, ben_wr};
        net     = $signed({1'b0, benefit}) - $signed({2'b00, cost});
    end

    // R3: a loss can only come from migrations
    assert_neg_needs_mig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (net < 0) |-> (n_mig != '0 && lat_mig != '0));
endmodule

// File: rtl/hc_step_ctrl.sv
module hc_step_ctrl
    import hc_pkg::*;
#(
    parameter int NET_W  = 28,
    parameter int A_W    = 4,
    parameter int A_MAX  = 15,
    parameter int A_INIT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    q_end,
    input  logic signed [NET_W-1:0] net,
    output logic [A_W-1:0]          thr_a,
    output logic                    thr_valid
);
    localparam logic [A_W-1:0] A_TOP = A_W'(A_MAX);
    localparam logic [A_W-1:0] A_BOT = A_W'(1);
    localparam logic [A_W-1:0] A_RST = A_W'(A_INIT);

    hc_state_e               state, state_nx;
    hc_dec_e                 dec;
    logic                    go_up;
    logic [A_W-1:0]          a_nx;
    logic signed [NET_W-1:0] prev_net;

    // Decision from this quantum versus the last one
    always_comb begin
        if (net < 0)                dec = DEC_RAISE;
        else if (net > prev_net)    dec = DEC_FOLLOW;
        else                        dec = DEC_LOWER;
        go_up = (dec == DEC_RAISE) ||
                (dec == DEC_FOLLOW && state != ST_CLIMB_DOWN);
    end

    // Next direction state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNSET:      if (q_end) state_nx = go_up ? ST_CLIMB_UP : ST_CLIMB_DOWN;
            ST_CLIMB_UP:   if (q_end) state_nx = go_up ? ST_CLIMB_UP : ST_CLIMB_DOWN;
            ST_CLIMB_DOWN: if (q_end) state_nx = go_up ? ST_CLIMB_UP : ST_CLIMB_DOWN;
            default:       state_nx = ST_UNSET;
        endcase
    end

    // Clamped one-step move
    always_comb begin
        a_nx = thr_a;
        if (q_end) begin
            if (go_up) a_nx = (thr_a >= A_TOP) ? A_TOP : thr_a + A_W'(1);
            else       a_nx = (thr_a <= A_BOT) ? A_BOT : thr_a - A_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_UNSET;
            thr_a    <= A_RST;
            prev_net <= '0;
        end else begin
            state <= state_nx;
            thr_a <= a_nx;
            if (q_end) prev_net <= net;
        end
    end

    // Outputs
    always_comb begin
        thr_valid = (state != ST_UNSET);
    end

    assert_a_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_a >= A_BOT && thr_a <= A_TOP);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q_end |=> $stable(thr_a));
    assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_end && net < 0 && thr_a != A_TOP) |=> thr_a == A_W'($past(thr_a) + A_W'(1)));
    assert_lower_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_end && net >= 0 && net <= prev_net && thr_a != A_BOT)
        |=> thr_a == A_W'($past(thr_a) - A_W'(1)));
    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_valid) |-> $past(q_end));
    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_valid |=> thr_valid);
endmodule

// File: rtl/hc_threshold_tuner.sv
module hc_threshold_tuner
    import hc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int LAT_W   = 10,
    parameter int A_W     = 4,
    parameter int A_MAX   = 15,
    parameter int A_INIT  = 4,
    parameter int M_FIXED = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_mig,
    input  logic             ev_rd,
    input  logic             ev_wr,
    input  logic             q_end,
    input  logic [LAT_W-1:0] lat_mig,
    input  logic [LAT_W-1:0] lat_rd_slow,
    input  logic [LAT_W-1:0] lat_rd_fast,
    input  logic [LAT_W-1:0] lat_wr_slow,
    input  logic [LAT_W-1:0] lat_wr_fast,
    output logic [A_W-1:0]   thr_a,
    output logic [A_W-1:0]   thr_m,
    output logic             thr_valid
);
    localparam int NET_W = CNT_W + LAT_W + 2;

    logic [EV_NUM-1:0] ev_vec;
    logic [CNT_W-1:0]  cnt [EV_NUM];
    logic signed [NET_W-1:0] net;

    assign ev_vec = {ev_wr, ev_rd, ev_mig};
    assign thr_m  = A_W'(M_FIXED);

    for (genvar g = 0; g < EV_NUM; g++) begin : g_cnt
        hc_event_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst_n (rst_n),
            .ev  (ev_vec[g]),
            .clr (q_end),
            .cnt (cnt[g])
        );
    end

    hc_net_calc #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_net (
        .clk         (clk),
        .rst_n       (rst_n),
        .n_mig       (cnt[EV_MIG]),
        .n_rd        (cnt[EV_RD]),
        .n_wr        (cnt[EV_WR]),
        .lat_mig     (lat_mig),
        .lat_rd_slow (lat_rd_slow),
        .lat_rd_fast (lat_rd_fast),
        .lat_wr_slow (lat_wr_slow),
        .lat_wr_fast (lat_wr_fast),
        .net         (net)
    );

    hc_step_ctrl #(.NET_W(NET_W), .A_W(A_W), .A_MAX(A_MAX), .A_INIT(A_INIT)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_end     (q_end),
        .net       (net),
        .thr_a     (thr_a),
        .thr_valid (thr_valid)
    );
endmodule

// File: tb/sim_hc_threshold_tuner.sv
module sim_hc_threshold_tuner;
    localparam int CNT_W = 8;
    localparam int LAT_W = 10;
    localparam int A_W   = 4;
    localparam int A_MAX = 15;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_mig = 0, ev_rd = 0, ev_wr = 0, q_end = 0;
    logic [LAT_W-1:0] lat_mig = 20, lat_rd_slow = 50, lat_rd_fast = 10;
    logic [LAT_W-1:0] lat_wr_slow = 90, lat_wr_fast = 10;
    logic [A_W-1:0] thr_a, thr_m;
    logic thr_valid;

    always #2 clk = ~clk;

    hc_threshold_tuner #(.CNT_W(CNT_W), .LAT_W(LAT_W), .A_W(A_W), .A_MAX(A_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_mig(ev_mig), .ev_rd(ev_rd), .ev_wr(ev_wr),
        .q_end(q_end), .lat_mig(lat_mig), .lat_rd_slow(lat_rd_slow),
        .lat_rd_fast(lat_rd_fast), .lat_wr_slow(lat_wr_slow),
        .lat_wr_fast(lat_wr_fast), .thr_a(thr_a), .thr_m(thr_m), .thr_valid(thr_valid)
    );

    typedef struct { int a; bit valid; string tag; } exp_t;
    exp_t sb[$];
    int checks = 0, errors = 0;

    int    m_a = 4;
    int    m_dir = 0;      // 0 unset, 1 up, 2 down
    longint m_prev = 0;
    int    carry_mig = 0;
    bit    done = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat(int n);
        return (n > SAT) ? SAT : n;
    endfunction

    // Driver: pulses a quantum, predicts the decision, pushes it
    task automatic quantum(int nm, int nr, int nw, bit strobe_mig, string tag);
        int len, cm, cr, cw, up;
        longint gr, gw, net;
        exp_t e;
        len = (nm > nr) ? nm : nr;
        len = (nw > len) ? nw : len;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ev_mig = (i < nm); ev_rd = (i < nr); ev_wr = (i < nw);
        end
        @(negedge clk);
        ev_mig = strobe_mig; ev_rd = 0; ev_wr = 0;
        check("R8 hold between strobes", int'(thr_a), m_a);
        q_end = 1;
        cm = sat(nm + carry_mig); cr = sat(nr); cw = sat(nw);
        carry_mig = strobe_mig;
        gr = (lat_rd_slow > lat_rd_fast) ? longint'(lat_rd_slow) - longint'(lat_rd_fast) : 0;
        gw = (lat_wr_slow > lat_wr_fast) ? longint'(lat_wr_slow) - longint'(lat_wr_fast) : 0;
        net = longint'(cr) * gr + longint'(cw) * gw - longint'(cm) * longint'(lat_mig);
        if (net < 0)            up = 1;
        else if (net > m_prev)  up = (m_dir != 2) ? 1 : 0;
        else                    up = 0;
        if (up == 1) begin m_a = (m_a < A_MAX) ? m_a + 1 : A_MAX; m_dir = 1; end
        else begin m_a = (m_a > 1) ? m_a - 1 : 1; m_dir = 2; end
        m_prev = net;
        e.a = m_a; e.valid = 1; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        q_end = 0; ev_mig = 0;
    endtask

    // Monitor: after each strobe edge compare against the queue head
    initial begin
        forever begin
            @(posedge clk);
            if (q_end && rst_n) begin
                exp_t e;
                @(negedge clk);
                if (sb.size() == 0) begin
                    check("scoreboard underflow", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(e.tag, int'(thr_a), e.a);
                    check("R9 valid after strobe", int'(thr_valid), 1);
                    check("R10 miss threshold", int'(thr_m), 2);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset threshold", int'(thr_a), 4);
        check("R1 reset valid", int'(thr_valid), 0);
        check("R10 miss threshold", int'(thr_m), 2);
        // R1/R6: empty quantum, net 0 vs reset prev 0 -> lower
        quantum(0, 0, 0, 0, "R6 zero net lowers");
        quantum(10, 0, 0, 0, "R3 migrations only -> R4 raise");
        quantum(0, 10, 0, 0, "R5 follow up");
        quantum(0, 20, 0, 0, "R5 follow up again");
        quantum(0, 20, 0, 0, "R7 equal to previous lowers (R6)");
        quantum(0, 30, 0, 0, "R5 follow down");
        quantum(0, 10, 5, 0, "R3 mixed benefit, R6 lower");
        quantum(2, 0, 4, 0, "R3 writes minus migrations");
        quantum(0, 0, 0, 0, "R6 lower to floor");
        repeat (6) quantum(0, 0, 0, 0, "R8 floor clamp");
        repeat (16) quantum(1, 0, 0, 0, "R8 ceiling clamp via R4");
        // R2: a migration in the strobe cycle belongs to the next quantum
        quantum(0, 0, 0, 1, "R2 strobe-cycle event");
        quantum(0, 0, 0, 0, "R2 carried migration raises");
        // R3: negative read gap clamps to zero saving
        lat_rd_fast = 60;
        quantum(0, 15, 0, 0, "R3 clamped read gap");
        lat_rd_fast = 10; lat_rd_slow = 11; lat_wr_slow = 12;
        quantum(0, 0, 128, 0, "R2 prep net 256");
        quantum(0, 300, 0, 0, "R2 saturated reads lower");
        quantum(0, 300, 0, 0, "R2 saturation again");
        repeat (4) @(negedge clk);
        check("scoreboard drained", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule